// File: doc/BRIEF.md
# Manchester II repeater and decoder

This block takes a Manchester II coded serial line, sampled by a local clock running at 16 or 32 times the bit rate. It does two jobs from one sampling engine. It re-drives the received line as a complementary output pair, delayed by half a bit, together with a clock at twice the bit rate. It also decodes the line to NRZ data with a bit-rate clock. It recognises the two sync types, flags cells that carry no valid mid-cell transition, and drives a reset output that a received word can release.

A word is a three-bit-period sync followed by `WORD_BITS` Manchester cells. A command sync is 1.5 bit times high then 1.5 bit times low, and a data sync is the reverse. A cell that is high then low is a 1, and a cell that is low then high is a 0. The first data bit after a sync is the reset bit.

Top module: `manch_repeat_dec`

## Requirements
- R1: `fast_mode` = 0 selects N = 16 sample clocks per bit, and `fast_mode` = 1 selects N = 32. All decode and repeat timing scales with N.
- R2: The selected line is `pos_in` whenever `pos_in` or `neg_in` is high. Otherwise it is `line_in`, so a unipolar source drives `line_in` and holds both bipolar inputs low.
- R3: While `send_en_n` is low, `rep_pos` equals the selected line delayed by exactly N/2 sample clocks, and `rep_neg` is its complement.
- R4: While `send_en_n` is low, `clk2x_out` is a square wave with a period of N/2 sample clocks.
- R5: While `send_en_n` is high, `rep_pos`, `rep_neg` and `clk2x_out` stay low whatever the line does. A change of `send_en_n` starts no sequence of its own.
- R6: A sync is recognised when a level has run 1.25 to 2.25 bit times and the opposite level has then run 1.25 bit times. `cmd_sync` takes the level of the first run: 1 for a command sync, 0 for a data sync. A data sync must follow line activity, so that its low half is not merged into an idle-low line.
- R7: After a sync, the `WORD_BITS` cells that follow are decoded. Each decoded bit appears on `nrz_out` a quarter bit before `bit_clk` rises. `bit_clk` is high for the first half of the next cell and gives one rising edge per bit.
- R8: `nrz_out` does not change while `bit_clk` is high.
- R9: A cell whose two halves have the same level raises `bad_code` for N sample clocks, starting at the next cell boundary. No further bits are decoded until the next sync.
- R10: While `rst_n` is low, `nrz_out`, `bit_clk`, `bad_code` and `word_rst_n` are low.
- R11: `word_rst_n` stays low after reset. At the second valid bit of each word it becomes the inverse of that word's first bit, so it is released only by a sync followed by a reset bit of 0 and a second valid bit.
- R12: `cmd_sync` changes only when a sync is recognised and holds its value through idle periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16X or 32X the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 0: 16 samples per bit, 1: 32 samples per bit |
| line_in | input | 1 | Unipolar non-inverted Manchester II input |
| pos_in | input | 1 | Bipolar one input |
| neg_in | input | 1 | Bipolar zero input |
| send_en_n | input | 1 | Active-low enable for the repeated outputs and 2X clock |
| rep_pos | output | 1 | Repeated line, delayed half a bit |
| rep_neg | output | 1 | Complement of the repeated line |
| clk2x_out | output | 1 | Clock at twice the bit rate |
| nrz_out | output | 1 | Decoded NRZ data |
| bit_clk | output | 1 | Bit-rate data clock |
| bad_code | output | 1 | Invalid Manchester cell flag |
| cmd_sync | output | 1 | Type of the last sync: 1 command, 0 data |
| word_rst_n | output | 1 | Reset output released by a received word |

## Verification
The bench sends back-to-back words in which the tail of one bit merges with the next sync into a two-bit run. A detector that uses too narrow a window would miss that sync and drop a whole word from the scoreboard. It also sends a data sync at both rates, which a design that assumes command syncs only would report with the wrong `cmd_sync`. It injects a cell with no mid-cell transition: a design that resumes decoding after the error would produce extra bit clocks, and one with the wrong pulse length shows a `bad_code` width other than N. It measures the repeat delay and the 2X clock period at both rates, where an off-by-one tap shows up as a delay of N/2 plus or minus one. It also checks that `word_rst_n` follows the reset bit of each word and stays low across a fresh reset with an idle line.

// File: rtl/manch_repeat_dec.sv
module manch_repeat_dec #(
  parameter int WORD_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_mode,
  input  logic line_in,
  input  logic pos_in,
  input  logic neg_in,
  input  logic send_en_n,
  output logic rep_pos,
  output logic rep_neg,
  output logic clk2x_out,
  output logic nrz_out,
  output logic bit_clk,
  output logic bad_code,
  output logic cmd_sync,
  output logic word_rst_n
);
  localparam int BCW = $clog2(WORD_BITS + 1);
  typedef enum logic {HUNT, DEC} st_t;

  st_t            st;
  logic           s1, s_q, a, pend, epend, rbit;
  logic [13:0]    sh;
  logic [6:0]     rl, prv;
  logic [4:0]     ph;
  logic [BCW-1:0] bc;

  logic [5:0] nb;
  logic [4:0] q1, q3, hb, last;
  logic [6:0] kmin, kmax;
  logic       line_sel, tap, edge_nx, confirm;

  assign nb       = fast_mode ? 6'd32 : 6'd16;
  assign q1       = 5'(nb >> 2);
  assign hb       = 5'(nb >> 1);
  assign q3       = hb + q1;
  assign last     = 5'(nb - 6'd1);
  assign kmin     = 7'(nb) + 7'(nb >> 2);
  assign kmax     = 7'(nb) + 7'(nb) + 7'(nb >> 2);
  assign line_sel = (pos_in | neg_in) ? pos_in : line_in;
  assign edge_nx  = s1 != s_q;
  assign confirm  = (st == HUNT) && (rl == kmin + 7'd1) && (prv >= kmin) && (prv <= kmax);

  assign tap       = fast_mode ? sh[13] : sh[5];
  assign rep_pos   = ~send_en_n & tap;
  assign rep_neg   = ~send_en_n & ~tap;
  assign clk2x_out = ~send_en_n & (fast_mode ? ph[3] : ph[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s_q <= 1'b0; sh <= '0; rl <= '0; prv <= '0; ph <= '0;
    end else begin
      s1  <= line_sel;
      s_q <= s1;
      sh  <= {sh[12:0], s_q};
      if (edge_nx) begin
        rl  <= 7'd1;
        prv <= rl;
      end else if (rl != 7'h7f) begin
        rl <= rl + 7'd1;
      end
      if (confirm)         ph <= q3 + 5'd1;
      else if (ph == last) ph <= '0;
      else                 ph <= ph + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= HUNT; bc <= '0; a <= 1'b0; rbit <= 1'b1; pend <= 1'b0; epend <= 1'b0;
      nrz_out <= 1'b0; bit_clk <= 1'b0; bad_code <= 1'b0; cmd_sync <= 1'b0; word_rst_n <= 1'b0;
    end else begin
      if (confirm) begin
        st       <= DEC;
        bc       <= '0;
        cmd_sync <= ~s_q;
      end else if (st == DEC) begin
        if (ph == q1) a <= s_q;
        if (ph == q3) begin
          if (s_q == a) begin
            epend <= 1'b1;
            st    <= HUNT;
          end else begin
            nrz_out <= a;
            pend    <= 1'b1;
            if (bc == '0) rbit <= a;
            if (bc == BCW'(1)) word_rst_n <= ~rbit;
            if (bc == BCW'(WORD_BITS - 1)) st <= HUNT;
            bc <= bc + 1'b1;
          end
        end
      end
      if (ph == last) begin
        bit_clk  <= pend;
        bad_code <= epend;
        pend     <= 1'b0;
        epend    <= 1'b0;
      end else if (ph == hb - 5'd1) begin
        bit_clk <= 1'b0;
      end
    end
  end

  assert_reset_low_R10: assert property (@(posedge clk)
    !rst_n |-> (!nrz_out && !bit_clk && !bad_code && !word_rst_n));

  assert_bitclk_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_clk) |-> ph == 5'd0);

  assert_nrz_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_clk && $past(bit_clk)) |-> $stable(nrz_out));

  assert_bad_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |-> !bit_clk);

  assert_sync_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_sync) |-> $past(confirm));

  assert_rst_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_rst_n) |-> $past(st) == DEC);
endmodule

// File: tb/tb_manch_repeat_dec.sv
module tb_manch_repeat_dec;
  localparam int WB = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, fast = 1'b0, lv = 1'b0, bip = 1'b0, cts_n = 1'b1;
  logic rep_pos, rep_neg, clk2x_out, nrz_out, bit_clk, bad_code, cmd_sync, word_rst_n;
  logic line_in, pos_in, neg_in;

  assign line_in = bip ? 1'b0 : lv;
  assign pos_in  = bip ? lv : 1'b0;
  assign neg_in  = bip ? ~lv : 1'b0;

  manch_repeat_dec #(.WORD_BITS(WB)) dut (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast), .line_in(line_in), .pos_in(pos_in),
    .neg_in(neg_in), .send_en_n(cts_n), .rep_pos(rep_pos), .rep_neg(rep_neg),
    .clk2x_out(clk2x_out), .nrz_out(nrz_out), .bit_clk(bit_clk), .bad_code(bad_code),
    .cmd_sync(cmd_sync), .word_rst_n(word_rst_n));

  int  hb_c = 8;
  int  n_chk = 0, n_bad = 0, bad_cyc = 0, bad_rise = 0;
  bit  exp_q[$];
  bit  last_nrz, e_bit;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge bit_clk) begin
    last_nrz = nrz_out;
    if (exp_q.size() == 0) chk(1'b0, "R7 unexpected decoded bit", nrz_out, 0);
    else begin
      e_bit = exp_q.pop_front();
      chk(nrz_out == e_bit, "R7 decoded bit", nrz_out, e_bit);
    end
  end

  always @(negedge bit_clk)
    if (rst_n) chk(nrz_out == last_nrz, "R8 nrz_out changed while bit_clk high", nrz_out, last_nrz);

  always @(negedge clk) if (bad_code) bad_cyc++;
  always @(posedge bad_code) bad_rise++;

  task automatic half(input bit l);
    lv = l;
    repeat (hb_c) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit push);
    half(b);
    half(!b);
    if (push) exp_q.push_back(b);
  endtask

  task automatic send_word(input bit cmd, input logic [WB-1:0] w);
    repeat (3) half(cmd);
    repeat (3) half(!cmd);
    for (int i = 0; i < WB; i++) send_bit(w[WB-1-i], 1'b1);
  endtask

  task automatic idle(input int bits);
    lv = 1'b0;
    repeat (bits * 2 * hb_c) @(negedge clk);
  endtask

  task automatic wait_lvl(input bit v);
    for (int k = 0; k < 200; k++) begin
      if (clk2x_out == v) break;
      @(negedge clk);
    end
  endtask

  task automatic meas_clk2x(input int expp, input string tag);
    int c;
    c = 0;
    wait_lvl(1'b0);
    wait_lvl(1'b1);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); c++;
      if (clk2x_out == 1'b0) break;
    end
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); c++;
      if (clk2x_out == 1'b1) break;
    end
    chk(c == expp, tag, c, expp);
  endtask

  task automatic meas_delay(input int expd, input string tag);
    int got;
    got = 0;
    lv = 1'b0;
    repeat (100) @(negedge clk);
    lv = 1'b1;
    for (int j = 1; j <= 100; j++) begin
      @(negedge clk);
      if (rep_pos && got == 0) begin
        got = j;
        chk(rep_neg == 1'b0, "R3 rep_neg complement", rep_neg, 0);
      end
    end
    chk(got == expd, tag, got, expd);
    lv = 1'b0;
    repeat (100) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    bit quiet;
    repeat (5) @(negedge clk);
    chk(!nrz_out && !bit_clk && !bad_code && !word_rst_n, "R10 outputs low in reset",
        {nrz_out, bit_clk, bad_code, word_rst_n}, 0);
    rst_n = 1'b1;

    quiet = 1'b1;
    lv = 1'b1;
    for (int k = 0; k < 160; k++) begin
      @(negedge clk);
      if (k == 60) lv = 1'b0;
      if (rep_pos || rep_neg || clk2x_out) quiet = 1'b0;
    end
    chk(quiet, "R5 repeat outputs held low while disabled", quiet, 1);
    chk(!word_rst_n, "R11 word_rst_n low after reset", word_rst_n, 0);

    cts_n = 1'b0;
    meas_clk2x(8, "R4 clk2x period at 16X");
    meas_delay(8, "R3 repeat delay at 16X");

    send_word(1'b1, 16'h5A3C);
    chk(cmd_sync == 1'b1, "R6 command sync type", cmd_sync, 1);
    send_word(1'b0, 16'hC3A5);
    idle(3);
    chk(cmd_sync == 1'b0, "R6 data sync type", cmd_sync, 0);
    chk(!word_rst_n, "R11 reset bit 1 holds word_rst_n low", word_rst_n, 0);
    idle(4);
    chk(cmd_sync == 1'b0, "R12 cmd_sync holds through idle", cmd_sync, 0);
    chk(bad_rise == 0, "R7 no bad_code on valid words", bad_rise, 0);

    repeat (3) half(1'b1);
    repeat (3) half(1'b0);
    send_bit(1'b0, 1'b1);
    send_bit(1'b1, 1'b1);
    send_bit(1'b1, 1'b1);
    half(1'b0);
    half(1'b0);
    idle(4);
    chk(bad_rise == 1, "R9 one bad_code pulse", bad_rise, 1);
    chk(bad_cyc == 16, "R9 bad_code width N", bad_cyc, 16);
    chk(exp_q.size() == 0, "R9 bits before error delivered", exp_q.size(), 0);
    chk(word_rst_n == 1'b1, "R11 release after reset bit 0", word_rst_n, 1);

    bip = 1'b1;
    send_word(1'b1, 16'h1234);
    idle(3);
    bip = 1'b0;
    chk(exp_q.size() == 0, "R2 bipolar word decoded", exp_q.size(), 0);
    chk(cmd_sync == 1'b1, "R2 bipolar command sync", cmd_sync, 1);

    fast = 1'b1;
    hb_c = 16;
    idle(2);
    meas_clk2x(16, "R1 R4 clk2x period at 32X");
    meas_delay(16, "R1 R3 repeat delay at 32X");
    send_word(1'b1, 16'h0F0F);
    send_word(1'b0, 16'hF00F);
    idle(3);
    chk(cmd_sync == 1'b0, "R1 R6 data sync at 32X", cmd_sync, 0);
    chk(!word_rst_n, "R1 R11 word_rst_n at 32X", word_rst_n, 0);
    chk(exp_q.size() == 0, "R1 R7 all 32X bits delivered", exp_q.size(), 0);

    send_word(1'b1, 16'h00FF);
    idle(3);
    chk(word_rst_n == 1'b1, "R11 release at 32X", word_rst_n, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!nrz_out && !bit_clk && !bad_code && !word_rst_n, "R10 outputs low in mid reset",
        {nrz_out, bit_clk, bad_code, word_rst_n}, 0);
    rst_n = 1'b1;
    idle(3);
    chk(!word_rst_n, "R11 stays low after reset with idle line", word_rst_n, 0);
    chk(exp_q.size() == 0, "R7 scoreboard empty", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end
endmodule